// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Array

This block is a fully associative array of page translations. Each slot holds a valid flag, a virtual page tag, a physical page number, an address-space number, a global flag, a four-bit read-enable mask and a four-bit write-enable mask, and two fault flags: one for reads and one for writes. Each mask has one bit per privilege mode, with bit 0 for the most privileged mode.

A combinational lookup port compares a virtual page number and the current address-space number against every slot. It returns the fields of the matching slot in the same cycle.

New translations are written at a round-robin victim pointer, with no use-based replacement. Three invalidation commands remove translations:
- wipe the whole array;
- drop every non-global translation;
- drop the translations of one page for one address space.

The slot under the victim pointer is always visible on an indexed-read port. A separate input steps the pointer without writing.

Top module: `tlb_asn_array`

## Requirements
- R1: While `rst` is high at a rising edge, every slot becomes all-zero and the victim pointer becomes 0. After reset, `lk_hit` and `ix_valid` are 0.
- R2: A slot matches a lookup when it is valid, its tag equals `lk_vpn`, and it is either global or its address-space number equals `lk_asn`. On a match, `lk_hit` is 1 and `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_fault_rd` and `lk_fault_wr` carry that slot's fields in the same cycle, with no clock edge in between. With no match, `lk_hit` is 0 and all these fields are 0.
- R3: When several slots match, the lowest-indexed one is returned, and `lk_idx` gives its index.
- R4: An accepted insert writes its fields into the slot under the victim pointer, whatever that slot held, and marks it valid. The pointer then moves up by one, wrapping from ENTRIES-1 to 0.
- R5: `flush_all` sets every field of every slot to zero and sets the victim pointer to 0.
- R6: `flush_proc` clears the valid flag of every non-global slot. Global slots keep their valid flag, and the other fields of every slot stay unchanged.
- R7: `flush_page` clears the valid flag of every slot that would match a lookup of (`fl_vpn`, `fl_asn`) under the rule of R2. All other slots are unchanged.
- R8: The `ix_*` outputs show the slot under the victim pointer. `ix_adv` moves the pointer up by one, with the same wrap as R4. Without an insert or `ix_adv`, the pointer holds.
- R9: In one cycle, command priority is `flush_all`, then `flush_proc`, then `flush_page`, then `ins_en`, and a lower command is ignored when a higher one is present. The pointer moves up by exactly one when an insert is accepted, when `ix_adv` is high, or when both happen. `flush_all` overrides any pointer movement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 43 | Lookup virtual page number |
| lk_asn | input | 8 | Lookup address-space number |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | $clog2(ENTRIES) | Index of matching slot |
| lk_ppn | output | 28 | Physical page number of match |
| lk_rd_en | output | 4 | Read-enable mask of match |
| lk_wr_en | output | 4 | Write-enable mask of match |
| lk_fault_rd | output | 1 | Fault-on-read flag of match |
| lk_fault_wr | output | 1 | Fault-on-write flag of match |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | 43 | Tag for new slot |
| ins_ppn | input | 28 | Physical page for new slot |
| ins_asn | input | 8 | Address-space number for new slot |
| ins_global | input | 1 | Global flag for new slot |
| ins_rd_en | input | 4 | Read-enable mask for new slot |
| ins_wr_en | input | 4 | Write-enable mask for new slot |
| ins_fault_rd | input | 1 | Fault-on-read flag for new slot |
| ins_fault_wr | input | 1 | Fault-on-write flag for new slot |
| flush_all | input | 1 | Wipe all slots, pointer to 0 |
| flush_proc | input | 1 | Invalidate non-global slots |
| flush_page | input | 1 | Invalidate one page |
| fl_vpn | input | 43 | Page for flush_page |
| fl_asn | input | 8 | Address space for flush_page |
| ix_adv | input | 1 | Step victim pointer |
| ix_valid | output | 1 | Valid flag of slot at pointer |
| ix_tag | output | 43 | Tag of slot at pointer |
| ix_ppn | output | 28 | Physical page of slot at pointer |
| ix_asn | output | 8 | Address-space number of slot at pointer |
| ix_global | output | 1 | Global flag of slot at pointer |

## Verification
The bench loads one tag under several address spaces, some of them global, so that lookups match more than one slot. A wrong priority encoder would then return a higher index, and a missing global test would miss a hit. It fills the array past its last slot to show that the pointer wraps and that the oldest translation is overwritten. A wrap error would leave stale data in slot 0 or write past the end. The page flush is aimed at a global slot and at a same-tag slot of another address space, which catches a flush that ignores the global flag or over-invalidates. Commands are also raised together: a priority error shows up as an insert that lands after a wipe, or as a pointer that is not at 0.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int TAG_W  = 43;
    localparam int ASN_W  = 8;
    localparam int PPN_W  = 28;
    localparam int MODES  = 4;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        logic [ASN_W-1:0] asn;
        logic             glob;
        logic [MODES-1:0] rd_en;
        logic [MODES-1:0] wr_en;
        logic             f_rd;
        logic             f_wr;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FLUSH_ALL,
        OP_FLUSH_PROC,
        OP_FLUSH_PAGE,
        OP_INSERT
    } tlb_op_e;

    // valid slot, same tag, and global or same address space
    function automatic logic entry_match(input tlb_entry_t e,
                                         input logic [TAG_W-1:0] vpn,
                                         input logic [ASN_W-1:0] asn);
        return e.valid && (e.tag == vpn) && (e.glob || (e.asn == asn));
    endfunction

    // highest-priority command wins
    function automatic tlb_op_e pick_op(input logic fa, input logic fp,
                                        input logic fpg, input logic ins);
        if (fa)       return OP_FLUSH_ALL;
        else if (fp)  return OP_FLUSH_PROC;
        else if (fpg) return OP_FLUSH_PAGE;
        else if (ins) return OP_INSERT;
        return OP_NONE;
    endfunction
endpackage

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            ptr <= '0;
        else if (step)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        hit = |match;
        idx = '0;
        // scanning downward leaves the lowest matching index last
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i])
                idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  tlb_op_e          op,
    input  logic [IDX_W-1:0] ptr,
    input  tlb_entry_t       wr_entry,
    input  logic [TAG_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    output tlb_entry_t       ent [ENTRIES]
);
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        tlb_entry_t slot_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else begin
                unique case (op)
                    OP_FLUSH_ALL:  slot_q <= '0;
                    OP_FLUSH_PROC: if (!slot_q.glob) slot_q.valid <= 1'b0;
                    OP_FLUSH_PAGE: if (entry_match(slot_q, fl_vpn, fl_asn))
                                       slot_q.valid <= 1'b0;
                    OP_INSERT:     if (ptr == IDX_W'(gi)) slot_q <= wr_entry;
                    default:       ;
                endcase
            end
        end

        assign ent[gi] = slot_q;
    end
endmodule

// File: rtl/tlb_asn_array.sv
module tlb_asn_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [42:0]      lk_vpn,
    input  logic [7:0]       lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [27:0]      lk_ppn,
    output logic [3:0]       lk_rd_en,
    output logic [3:0]       lk_wr_en,
    output logic             lk_fault_rd,
    output logic             lk_fault_wr,
    input  logic             ins_en,
    input  logic [42:0]      ins_vpn,
    input  logic [27:0]      ins_ppn,
    input  logic [7:0]       ins_asn,
    input  logic             ins_global,
    input  logic [3:0]       ins_rd_en,
    input  logic [3:0]       ins_wr_en,
    input  logic             ins_fault_rd,
    input  logic             ins_fault_wr,
    input  logic             flush_all,
    input  logic             flush_proc,
    input  logic             flush_page,
    input  logic [42:0]      fl_vpn,
    input  logic [7:0]       fl_asn,
    input  logic             ix_adv,
    output logic             ix_valid,
    output logic [42:0]      ix_tag,
    output logic [27:0]      ix_ppn,
    output logic [7:0]       ix_asn,
    output logic             ix_global
);
    tlb_op_e              op;
    tlb_entry_t           new_entry;
    tlb_entry_t           ent [ENTRIES];
    tlb_entry_t           hit_entry;
    tlb_entry_t           cur_entry;
    logic [ENTRIES-1:0]   match;
    logic [IDX_W-1:0]     ptr;
    logic                 ptr_step;

    assign op = pick_op(flush_all, flush_proc, flush_page, ins_en);

    always_comb begin
        new_entry       = '0;
        new_entry.valid = 1'b1;
        new_entry.tag   = ins_vpn;
        new_entry.ppn   = ins_ppn;
        new_entry.asn   = ins_asn;
        new_entry.glob  = ins_global;
        new_entry.rd_en = ins_rd_en;
        new_entry.wr_en = ins_wr_en;
        new_entry.f_rd  = ins_fault_rd;
        new_entry.f_wr  = ins_fault_wr;
    end

    assign ptr_step = (op == OP_INSERT) || ix_adv;

    tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .clear (op == OP_FLUSH_ALL),
        .step  (ptr_step),
        .ptr   (ptr)
    );

    tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ptr      (ptr),
        .wr_entry (new_entry),
        .fl_vpn   (fl_vpn),
        .fl_asn   (fl_asn),
        .ent      (ent)
    );

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign match[gi] = entry_match(ent[gi], lk_vpn, lk_asn);
    end

    tlb_hit_select #(.ENTRIES(ENTRIES)) u_sel (
        .match (match),
        .hit   (lk_hit),
        .idx   (lk_idx)
    );

    assign hit_entry   = lk_hit ? ent[lk_idx] : '0;
    assign lk_ppn      = hit_entry.ppn;
    assign lk_rd_en    = hit_entry.rd_en;
    assign lk_wr_en    = hit_entry.wr_en;
    assign lk_fault_rd = hit_entry.f_rd;
    assign lk_fault_wr = hit_entry.f_wr;

    assign cur_entry = ent[ptr];
    assign ix_valid  = cur_entry.valid;
    assign ix_tag    = cur_entry.tag;
    assign ix_ppn    = cur_entry.ppn;
    assign ix_asn    = cur_entry.asn;
    assign ix_global = cur_entry.glob;
endmodule

// File: rtl/tlb_asn_array_chk.sv
module tlb_asn_array_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst,
    input logic [TAG_W-1:0] lk_vpn,
    input logic [ASN_W-1:0] lk_asn,
    input logic             lk_hit,
    input logic [IDX_W-1:0] lk_idx,
    input logic [PPN_W-1:0] lk_ppn,
    input logic [MODES-1:0] lk_rd_en,
    input logic [MODES-1:0] lk_wr_en,
    input logic             lk_fault_rd,
    input logic             lk_fault_wr,
    input logic             ins_en,
    input logic             flush_all,
    input logic             flush_proc,
    input logic             flush_page,
    input logic             ix_adv,
    input logic [IDX_W-1:0] ptr,
    input tlb_entry_t       ent [ENTRIES]
);
    logic [ENTRIES-1:0] vld, glb, own_match, below;
    logic               steps;
    tlb_entry_t         sel;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_v
        assign vld[gi]       = ent[gi].valid;
        assign glb[gi]       = ent[gi].glob;
        assign own_match[gi] = ent[gi].valid && ent[gi].tag == lk_vpn &&
                               (ent[gi].glob || ent[gi].asn == lk_asn);
    end
    assign below = (ENTRIES'(1) << lk_idx) - ENTRIES'(1);
    assign sel   = ent[lk_idx];
    assign steps = !flush_all && ((ins_en && !flush_proc && !flush_page) || ix_adv);

    // R1: reset empties the array and parks the pointer
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (vld == '0 && ptr == '0));

    // R2: a reported hit names a slot that truly matches and carries its fields
    p_hit_fields_r2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (own_match[lk_idx] && lk_ppn == sel.ppn && lk_rd_en == sel.rd_en &&
                    lk_wr_en == sel.wr_en && lk_fault_rd == sel.f_rd &&
                    lk_fault_wr == sel.f_wr));

    // R3: no matching slot sits below the reported index
    p_lowest_wins_r3: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ((own_match & below) == '0));

    // R4 / R8: pointer wraps from the last slot
    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (steps && ptr == IDX_W'(ENTRIES - 1)) |=> ptr == '0);

    // R5: wipe clears every slot and the pointer
    p_flush_all_r5: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (vld == '0 && ptr == '0));

    // R6: only global slots survive a process flush
    p_flush_proc_r6: assert property (@(posedge clk) disable iff (rst)
        (flush_proc && !flush_all) |=> vld == $past(vld & glb));

    // R8: pointer holds when nothing steps it
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!flush_all && !steps) |=> $stable(ptr));
endmodule

bind tlb_asn_array tlb_asn_array_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_vpn      (lk_vpn),
    .lk_asn      (lk_asn),
    .lk_hit      (lk_hit),
    .lk_idx      (lk_idx),
    .lk_ppn      (lk_ppn),
    .lk_rd_en    (lk_rd_en),
    .lk_wr_en    (lk_wr_en),
    .lk_fault_rd (lk_fault_rd),
    .lk_fault_wr (lk_fault_wr),
    .ins_en      (ins_en),
    .flush_all   (flush_all),
    .flush_proc  (flush_proc),
    .flush_page  (flush_page),
    .ix_adv      (ix_adv),
    .ptr         (ptr),
    .ent         (ent)
);

// File: tb/sim_tlb_asn_array.sv
module sim_tlb_asn_array;
    import tlb_pkg::*;

    localparam int  N          = 8;
    localparam int  IW         = $clog2(N);
    localparam time CLK_PERIOD = 10;
    localparam logic [42:0] TB = 43'h123_4560_0000;

    logic clk = 1'b0, rst = 1'b1;
    logic [42:0] lk_vpn = '0, ins_vpn = '0, fl_vpn = '0;
    logic [7:0]  lk_asn = '0, ins_asn = '0, fl_asn = '0;
    logic [27:0] ins_ppn = '0;
    logic [3:0]  ins_rd_en = '0, ins_wr_en = '0;
    logic ins_en = 0, ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
    logic flush_all = 0, flush_proc = 0, flush_page = 0, ix_adv = 0;
    logic lk_hit, lk_fault_rd, lk_fault_wr, ix_valid, ix_global;
    logic [IW-1:0] lk_idx;
    logic [27:0] lk_ppn, ix_ppn;
    logic [3:0]  lk_rd_en, lk_wr_en;
    logic [42:0] ix_tag;
    logic [7:0]  ix_asn;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    tlb_entry_t m [N];
    int m_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_asn_array #(.ENTRIES(N)) u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit mdl_hit(input int i, input logic [42:0] v, input logic [7:0] a);
        return m[i].valid && m[i].tag == v && (m[i].glob || m[i].asn == a);
    endfunction

    function automatic int mdl_lookup(input logic [42:0] v, input logic [7:0] a);
        for (int i = 0; i < N; i++) if (mdl_hit(i, v, a)) return i;
        return -1;
    endfunction

    function automatic tlb_entry_t mk(input logic [42:0] t, input logic [7:0] a,
                                      input logic g, input logic [27:0] p);
        tlb_entry_t e = '0;
        e.valid = 1; e.tag = t; e.asn = a; e.glob = g; e.ppn = p;
        e.rd_en = p[3:0]; e.wr_en = p[7:4]; e.f_rd = p[8]; e.f_wr = p[9];
        return e;
    endfunction

    // compare combinational outputs against the model
    task automatic compare_outputs;
        int w = mdl_lookup(lk_vpn, lk_asn);
        chk("R2 hit", 64'(lk_hit), 64'(w >= 0));
        if (w >= 0) begin
            chk("R3 idx", 64'(lk_idx), 64'(w));
            chk("R2 fields", {lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr},
                {m[w].ppn, m[w].rd_en, m[w].wr_en, m[w].f_rd, m[w].f_wr});
        end else begin
            chk("R2 miss zero", {lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr}, '0);
        end
        chk("R8 ix", {ix_valid, ix_tag}, {m[m_ptr].valid, m[m_ptr].tag});
        chk("R8 ix2", {ix_ppn, ix_asn, ix_global}, {m[m_ptr].ppn, m[m_ptr].asn, m[m_ptr].glob});
    endtask

    task automatic step(input logic fa, input logic fp, input logic fpg, input logic ins,
                        input logic adv, input tlb_entry_t e,
                        input logic [42:0] fv, input logic [7:0] fasn,
                        input logic [42:0] lv, input logic [7:0] la);
        bit stepped;
        @(negedge clk);
        flush_all = fa; flush_proc = fp; flush_page = fpg; ins_en = ins; ix_adv = adv;
        ins_vpn = e.tag; ins_ppn = e.ppn; ins_asn = e.asn; ins_global = e.glob;
        ins_rd_en = e.rd_en; ins_wr_en = e.wr_en; ins_fault_rd = e.f_rd; ins_fault_wr = e.f_wr;
        fl_vpn = fv; fl_asn = fasn; lk_vpn = lv; lk_asn = la;
        #1 compare_outputs();
        @(posedge clk);
        stepped = adv;
        if (fa) begin
            for (int i = 0; i < N; i++) m[i] = '0;
        end else if (fp) begin
            for (int i = 0; i < N; i++) if (!m[i].glob) m[i].valid = 0;
        end else if (fpg) begin
            for (int i = 0; i < N; i++) if (mdl_hit(i, fv, fasn)) m[i].valid = 0;
        end else if (ins) begin
            m[m_ptr] = e; m[m_ptr].valid = 1; stepped = 1;
        end
        if (fa) m_ptr = 0;
        else if (stepped) m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
    endtask

    task automatic idle_probe(input logic [42:0] lv, input logic [7:0] la);
        @(negedge clk);
        flush_all = 0; flush_proc = 0; flush_page = 0; ins_en = 0; ix_adv = 0;
        lk_vpn = lv; lk_asn = la;
        #1;
    endtask

    task automatic ins(input tlb_entry_t e);
        step(0, 0, 0, 1, 0, e, '0, '0, e.tag, e.asn);
    endtask

    initial begin
        tlb_entry_t z = '0;
        void'($urandom(32'hC0FFEE));
        for (int i = 0; i < N; i++) m[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R1 hit after reset", 64'(lk_hit), 0);
        chk("R1 ix_valid after reset", 64'(ix_valid), 0);

        // fill past the end: slot 0 overwritten (R4)
        for (int i = 0; i <= N; i++) ins(mk(TB + 43'(i), 8'd1, 0, 28'(16 + i)));
        idle_probe(TB, 8'd1);
        chk("R4 oldest overwritten", 64'(lk_hit), 0);
        idle_probe(TB + 43'(N), 8'd1);
        chk("R4 new entry in slot 0", {lk_hit, 60'(lk_idx)}, {1'b1, 60'd0});
        chk("R4 pointer wrapped to 1", ix_tag, TB + 43'd1);

        // same tag under several spaces; global in a high slot (R3, R2)
        step(1, 0, 0, 0, 0, z, '0, '0, '0, '0);
        ins(mk(TB + 43'd40, 8'd2, 0, 28'h111));
        ins(mk(TB + 43'd40, 8'd3, 0, 28'h222));
        ins(mk(TB + 43'd40, 8'd3, 0, 28'h333));
        ins(mk(TB + 43'd40, 8'd9, 1, 28'h3A4));
        idle_probe(TB + 43'd40, 8'd3);
        chk("R3 lowest of two matches", {60'(lk_idx), lk_ppn}, {60'd1, 28'h222});
        idle_probe(TB + 43'd40, 8'd7);
        chk("R2 global matches foreign space", {lk_hit, 60'(lk_idx), lk_ppn}, {1'b1, 60'd3, 28'h3A4});
        chk("R2 global fields", {lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr}, {4'h4, 4'hA, 1'b1, 1'b1});

        // page flush for space 3: slots 1,2 and global slot 3 go, slot 0 stays (R7)
        step(0, 0, 1, 0, 0, z, TB + 43'd40, 8'd3, '0, '0);
        idle_probe(TB + 43'd40, 8'd2);
        chk("R7 other space survives page flush", {lk_hit, 60'(lk_idx)}, {1'b1, 60'd0});
        idle_probe(TB + 43'd40, 8'd7);
        chk("R7 global slot flushed", 64'(lk_hit), 0);

        // process flush keeps globals (R6)
        ins(mk(TB + 43'd50, 8'd5, 1, 28'h555));
        ins(mk(TB + 43'd51, 8'd5, 0, 28'h556));
        step(0, 1, 0, 0, 0, z, '0, '0, '0, '0);
        idle_probe(TB + 43'd50, 8'd0);
        chk("R6 global kept", 64'(lk_hit), 1);
        idle_probe(TB + 43'd51, 8'd5);
        chk("R6 non-global dropped", 64'(lk_hit), 0);

        // priority: wipe with insert and advance (R9, R5)
        step(1, 0, 0, 1, 1, mk(TB + 43'd60, 8'd0, 1, 28'h1), '0, '0, '0, '0);
        idle_probe(TB + 43'd60, 8'd0);
        chk("R9 insert ignored under wipe", 64'(lk_hit), 0);
        chk("R5 wipe leaves slot 0 zero", {ix_valid, ix_tag}, '0);
        // flush_page beats insert; advance still steps once (R9)
        step(0, 0, 1, 1, 1, mk(TB + 43'd61, 8'd0, 1, 28'h2), '0, '0, '0, '0);
        idle_probe(TB + 43'd61, 8'd0);
        chk("R9 insert ignored under page flush", 64'(lk_hit), 0);
        // insert plus advance steps once: next insert lands at slot 2 (R9)
        step(0, 0, 0, 1, 1, mk(TB + 43'd62, 8'd0, 1, 28'h3), '0, '0, '0, '0);
        ins(mk(TB + 43'd63, 8'd0, 1, 28'h4));
        idle_probe(TB + 43'd63, 8'd0);
        chk("R9 single step on insert+adv", 64'(lk_idx), 64'd2);
        // advance alone moves, idle holds (R8)
        step(0, 0, 0, 0, 1, z, '0, '0, '0, '0);
        idle_probe('0, '0);
        chk("R8 ix after adv", 64'(ix_valid), 0);

        // random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            int r = $urandom_range(0, 99);
            logic [42:0] tv = TB + 43'($urandom_range(0, 5));
            logic [7:0]  av = 8'($urandom_range(0, 3));
            tlb_entry_t e = mk(TB + 43'($urandom_range(0, 5)), 8'($urandom_range(0, 3)),
                               1'($urandom_range(0, 3) == 0), 28'($urandom));
            step(r < 2, (r >= 2 && r < 5) || r == 99, r >= 5 && r < 12,
                 r >= 12 && r < 60, r >= 55 && r < 70, e,
                 tv, 8'($urandom_range(0, 3)), tv, av);
        end
        // reset mid-run (R1)
        @(negedge clk); rst = 1; @(posedge clk); @(negedge clk); rst = 0; #1;
        for (int i = 0; i < N; i++) m[i] = '0;
        m_ptr = 0;
        chk("R1 reset mid-run", {ix_valid, ix_tag}, '0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule